// File: doc/BRIEF.md
# Single to Half Precision Rounder

This block narrows one 32-bit single-precision word to a 16-bit half-precision word, rounding to nearest with ties to even. The result has a sign bit in bit 15, a 5-bit exponent with bias 15 in bits 14:10, and a 10-bit fraction in bits 9:0. It handles every kind of input:

- normal values;
- values that fall below the half normal range, which are denormalised and then rounded;
- values too small for any subnormal, which go to signed zero;
- values too large to represent, which overflow;
- infinities and NaNs.

A per-word mode flag selects an alternative half format. In that format the top exponent code 31 holds ordinary numbers, so the format has no infinity and no NaN, and any value out of range saturates instead.

The input is a word qualified by a valid strobe. The result and three status flags (overflow, underflow, inexact) are registered when the strobe is high, so the output appears one cycle later with its own valid. The block has no FSM in the sequential sense. Each input word is sorted into one of six classes, and the class picks the output:

- `CL_ZERO`: exponent field 0, fraction 0.
- `CL_TINY`: single subnormal, or a value below 2^-25.
- `CL_FINITE`: a value that goes through the shifter and rounder.
- `CL_HUGE`: a value whose exponent is beyond every half code.
- `CL_INF`: an infinity.
- `CL_NAN`: a NaN.

The only register update happens when `in_vld` is high, and it takes the result of the class picked from the input word. When `in_vld` is low the registered result is held.

Top module: `sp2hp_rounder`

## Requirements
- R1: Normal results use round-to-nearest-even on the discarded 13 fraction bits. For example 0x3eaaaaab gives 0x3555, 0x3f801000 gives 0x3c00 (tie to even) and 0x3f803000 gives 0x3c02. The sign is bit 15 of the output.
- R2: In standard mode (`in_alt`=0), magnitudes up to 65519 give a finite result of at most 0x7bff. A magnitude of 65520 or more gives sign|0x7c00 with overflow and inexact set.
- R3: A result below 2^-14 is shifted into subnormal form (exponent code 0) and then rounded. 2^-24 gives 0x0001 exactly. A subnormal that rounds up past 0x03ff becomes 0x0400.
- R4: Magnitudes below 2^-25, including every single subnormal, give signed zero with underflow and inexact set. Exactly 2^-25 rounds to zero, and anything above it up to 2^-24 gives 0x0001.
- R5: In standard mode, an infinity input gives sign|0x7c00 with no flags. A NaN gives sign|0x7c00|0x0200 with input fraction bits 21:13 in output bits 8:0, and no flags.
- R6: In alternative mode, exponent code 31 holds normal values up to 131008 (0x7fff). Any larger rounded result saturates to sign|0x7fff with overflow and inexact set.
- R7: In alternative mode, infinity and NaN inputs give sign|0x7fff with overflow and inexact set.
- R8: Inexact is set when any nonzero bit is discarded or overflow occurs. Underflow is set when the exact value is below 2^-14 and inexact. Overflow is set only on overflow.
- R9: When `in_vld` is high, the output valid is high on the next cycle with that word's result and flags. When `in_vld` is low, the output valid drops and the result and flags hold their last value.
- R10: Reset drives the output valid, result and flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input word is valid this cycle |
| in_alt | input | 1 | 1 selects the alternative half format (no infinity or NaN) |
| in_word | input | 32 | Single-precision input word |
| out_vld | output | 1 | Registered result valid |
| out_half | output | 16 | Registered half-precision result |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The hardest cases to reach are those where the rounding carry crosses a boundary:

- a subnormal whose fraction is all ones and whose guard bit is set, so it must carry into the smallest normal;
- the last finite code, where the carry must reach the exponent code that is reserved in one mode and ordinary in the other.

The stimulus builds these words by hand from the exponent and the discarded bit pattern. Examples are 0x387fe000 for the subnormal carry, and 0x477ff000 and 0x47fff000 for the top-code carry in each mode. The exact 2^-25 tie is built the same way. The bench then checks one bit either side of each boundary to confirm the edge is exact.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int HP_EXP_W  = 5;
    localparam int HP_FRAC_W = 10;
    localparam int HP_W      = 1 + HP_EXP_W + HP_FRAC_W;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
    localparam int HP_BIAS   = (1 << (HP_EXP_W - 1)) - 1;
    localparam int MANT_W    = SP_FRAC_W + 1;
    localparam int DROP_W    = SP_FRAC_W - HP_FRAC_W;
    localparam int SH_W      = 5;
    localparam int HP_EMAX   = (1 << HP_EXP_W) - 1;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_TINY,
        CL_FINITE,
        CL_HUGE,
        CL_INF,
        CL_NAN
    } num_class_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } hflags_t;
endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify
    import hcvt_pkg::*;
#(
    parameter int EXP_W  = SP_EXP_W,
    parameter int FRAC_W = SP_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output num_class_e            cls,
    output logic [HP_EXP_W-1:0]   exp_field,
    output logic [SH_W-1:0]       sh,
    output logic [FRAC_W:0]       mant
);
    localparam int ESW = EXP_W + 2;
    localparam logic signed [ESW-1:0] BIAS_GAP = ESW'(SP_BIAS - HP_BIAS);
    localparam logic signed [ESW-1:0] EH_TOP   = ESW'(HP_EMAX);
    localparam logic signed [ESW-1:0] EH_LOW   = -ESW'(HP_FRAC_W);
    localparam logic signed [ESW-1:0] SUB_BASE = ESW'(DROP_W + 1);

    logic [EXP_W-1:0]         e_in;
    logic [FRAC_W-1:0]        f_in;
    logic signed [ESW-1:0]    eh;

    assign e_in = word[EXP_W+FRAC_W-1:FRAC_W];
    assign f_in = word[FRAC_W-1:0];
    assign eh   = $signed({2'b00, e_in}) - BIAS_GAP;
    assign mant = {|e_in, f_in};

    always_comb begin
        cls       = CL_ZERO;
        exp_field = '0;
        sh        = SH_W'(DROP_W);
        if (&e_in) begin
            cls = (|f_in) ? CL_NAN : CL_INF;
        end else if (e_in == '0) begin
            cls = (|f_in) ? CL_TINY : CL_ZERO;
        end else if (eh > EH_TOP) begin
            cls = CL_HUGE;
        end else if (eh < EH_LOW) begin
            cls = CL_TINY;
        end else begin
            cls = CL_FINITE;
            if (eh > 0) begin
                exp_field = HP_EXP_W'(eh);
            end else begin
                sh = SH_W'(SUB_BASE - eh);
            end
        end
    end
endmodule

// File: rtl/hcvt_round.sv
module hcvt_round
    import hcvt_pkg::*;
#(
    parameter int M_W = MANT_W,
    parameter int F_W = HP_FRAC_W,
    parameter int E_W = HP_EXP_W
) (
    input  logic [M_W-1:0]     mant,
    input  logic [SH_W-1:0]    sh,
    input  logic [E_W-1:0]     exp_field,
    output logic [E_W+F_W:0]   sum,
    output logic               inexact
);
    localparam int KEEP_W = M_W + F_W;

    logic [KEEP_W-1:0] ext;
    logic [F_W-1:0]    q;
    logic              guard_b;
    logic              sticky_b;
    logic              rup;

    assign ext      = KEEP_W'({mant, {M_W{1'b0}}} >> sh);
    assign q        = ext[KEEP_W-1:M_W];
    assign guard_b  = ext[M_W-1];
    assign sticky_b = |ext[M_W-2:0];
    assign rup      = guard_b & (sticky_b | q[0]);
    assign sum      = {1'b0, exp_field, q} + (E_W+F_W+1)'(rup);
    assign inexact  = guard_b | sticky_b;
endmodule

// File: rtl/sp2hp_rounder.sv
module sp2hp_rounder
    import hcvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic        in_alt,
    input  logic [31:0] in_word,
    output logic        out_vld,
    output logic [15:0] out_half,
    output logic        out_ovf,
    output logic        out_unf,
    output logic        out_inx
);
    localparam logic [HP_W-2:0] INF_MAG = {{HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
    localparam logic [HP_W-2:0] SAT_MAG = {(HP_W-1){1'b1}};
    localparam logic [HP_EXP_W:0] STD_TOP = (HP_EXP_W+1)'(HP_EMAX);

    num_class_e          cls;
    logic [HP_EXP_W-1:0] exp_field;
    logic [SH_W-1:0]     sh;
    logic [MANT_W-1:0]   mant;
    logic [HP_W-1:0]     sum;
    logic                rnd_inx;
    logic                sgn;
    logic [HP_W-1:0]     nx_half;
    hflags_t             nx_flg;

    assign sgn = in_word[SP_W-1];

    hcvt_classify u_classify (
        .word      (in_word),
        .cls       (cls),
        .exp_field (exp_field),
        .sh        (sh),
        .mant      (mant)
    );

    hcvt_round u_round (
        .mant      (mant),
        .sh        (sh),
        .exp_field (exp_field),
        .sum       (sum),
        .inexact   (rnd_inx)
    );

    // Output selection by input class.
    always_comb begin
        nx_half = {sgn, {(HP_W-1){1'b0}}};
        nx_flg  = '0;
        unique case (cls)
            CL_ZERO: begin
                nx_half = {sgn, {(HP_W-1){1'b0}}};
            end
            CL_TINY: begin
                nx_flg = '{ovf: 1'b0, unf: 1'b1, inx: 1'b1};
            end
            CL_FINITE: begin
                if (!in_alt && (sum[HP_W-1:HP_FRAC_W] >= STD_TOP)) begin
                    nx_half = {sgn, INF_MAG};
                    nx_flg  = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
                end else if (in_alt && sum[HP_W-1]) begin
                    nx_half = {sgn, SAT_MAG};
                    nx_flg  = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
                end else begin
                    nx_half = {sgn, sum[HP_W-2:0]};
                    nx_flg  = '{ovf: 1'b0,
                                unf: rnd_inx && (exp_field == '0),
                                inx: rnd_inx};
                end
            end
            CL_HUGE: begin
                nx_half = {sgn, in_alt ? SAT_MAG : INF_MAG};
                nx_flg  = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
            end
            CL_INF: begin
                nx_half = {sgn, in_alt ? SAT_MAG : INF_MAG};
                nx_flg  = in_alt ? '{ovf: 1'b1, unf: 1'b0, inx: 1'b1} : '0;
            end
            CL_NAN: begin
                if (in_alt) begin
                    nx_half = {sgn, SAT_MAG};
                    nx_flg  = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
                end else begin
                    nx_half = {sgn, {HP_EXP_W{1'b1}}, 1'b1,
                               in_word[SP_FRAC_W-2 -: HP_FRAC_W-1]};
                end
            end
            default: begin
                nx_half = '0;
            end
        endcase
    end

    // Result register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_half <= '0;
            out_ovf  <= 1'b0;
            out_unf  <= 1'b0;
            out_inx  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_half <= nx_half;
                out_ovf  <= nx_flg.ovf;
                out_unf  <= nx_flg.unf;
                out_inx  <= nx_flg.inx;
            end
        end
    end

    a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r9_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_half) && $stable(out_inx)));
    a_r8_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_inx);
    a_r8_unf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> (out_inx && !out_ovf));
    a_r3_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_FINITE) |-> (sh >= SH_W'(DROP_W) && sh <= SH_W'(DROP_W + HP_FRAC_W + 1)));
    a_r3_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_FINITE && exp_field == '0) |-> (sum <= HP_W'(1 << HP_FRAC_W)));
endmodule

// File: tb/test_sp2hp_rounder.sv
`timescale 1ns/1ps
module test_sp2hp_rounder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_alt = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_vld;
    logic [15:0] out_half;
    logic        out_ovf, out_unf, out_inx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sp2hp_rounder i_sp2hp_rounder (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_alt   (in_alt),
        .in_word  (in_word),
        .out_vld  (out_vld),
        .out_half (out_half),
        .out_ovf  (out_ovf),
        .out_unf  (out_unf),
        .out_inx  (out_inx)
    );

    // {req, alt, word, half, ovf, unf, inx}
    localparam int NV = 34;
    localparam logic [55:0] VEC [NV] = '{
        {4'd1, 1'b0, 32'h3f800000, 16'h3c00, 3'b000}, // R1 one
        {4'd1, 1'b0, 32'h3eaaaaab, 16'h3555, 3'b001}, // R1 third
        {4'd1, 1'b0, 32'h3f801000, 16'h3c00, 3'b001}, // R1 tie even down
        {4'd1, 1'b0, 32'h3f803000, 16'h3c02, 3'b001}, // R1 tie odd up
        {4'd1, 1'b0, 32'hc0000000, 16'hc000, 3'b000}, // R1 minus two
        {4'd2, 1'b0, 32'h477fe000, 16'h7bff, 3'b000}, // R2 65504
        {4'd2, 1'b0, 32'h477fef00, 16'h7bff, 3'b001}, // R2 65519
        {4'd2, 1'b0, 32'h477ff000, 16'h7c00, 3'b101}, // R2 65520
        {4'd2, 1'b0, 32'hc77ff000, 16'hfc00, 3'b101}, // R2 -65520
        {4'd2, 1'b0, 32'h47ffe000, 16'h7c00, 3'b101}, // R2 131008 std
        {4'd3, 1'b0, 32'h38800000, 16'h0400, 3'b000}, // R3 min normal
        {4'd3, 1'b0, 32'h33800000, 16'h0001, 3'b000}, // R3 min subnormal
        {4'd3, 1'b0, 32'h387fc000, 16'h03ff, 3'b000}, // R3 max subnormal
        {4'd3, 1'b0, 32'h387fe000, 16'h0400, 3'b011}, // R3 sub carries to normal
        {4'd4, 1'b0, 32'h33000000, 16'h0000, 3'b011}, // R4 exact tie 2^-25
        {4'd4, 1'b0, 32'h33000001, 16'h0001, 3'b011}, // R4 just above 2^-25
        {4'd4, 1'b0, 32'h32ffffff, 16'h0000, 3'b011}, // R4 just below
        {4'd4, 1'b0, 32'hb2ffffff, 16'h8000, 3'b011}, // R4 negative flush
        {4'd4, 1'b0, 32'h00000001, 16'h0000, 3'b011}, // R4 single subnormal
        {4'd4, 1'b0, 32'h80000000, 16'h8000, 3'b000}, // R4 minus zero
        {4'd5, 1'b0, 32'h7f800000, 16'h7c00, 3'b000}, // R5 +inf
        {4'd5, 1'b0, 32'hff800000, 16'hfc00, 3'b000}, // R5 -inf
        {4'd5, 1'b0, 32'h7fc00000, 16'h7e00, 3'b000}, // R5 quiet NaN
        {4'd5, 1'b0, 32'h7fa02000, 16'h7f01, 3'b000}, // R5 payload NaN
        {4'd5, 1'b0, 32'hff800001, 16'hfe00, 3'b000}, // R5 signalling NaN
        {4'd6, 1'b1, 32'h47ffe000, 16'h7fff, 3'b000}, // R6 131008 alt
        {4'd6, 1'b1, 32'h477ff000, 16'h7c00, 3'b001}, // R6 top code normal
        {4'd6, 1'b1, 32'h47fff000, 16'h7fff, 3'b101}, // R6 carry saturates
        {4'd6, 1'b1, 32'hc7fff000, 16'hffff, 3'b101}, // R6 negative saturates
        {4'd6, 1'b1, 32'h48000000, 16'h7fff, 3'b101}, // R6 huge saturates
        {4'd7, 1'b1, 32'h7f800000, 16'h7fff, 3'b101}, // R7 inf alt
        {4'd7, 1'b1, 32'hffc00000, 16'hffff, 3'b101}, // R7 NaN alt
        {4'd8, 1'b1, 32'h3eaaaaab, 16'h3555, 3'b001}, // R8 inexact only
        {4'd8, 1'b0, 32'h33800001, 16'h0001, 3'b011}  // R8 underflow tiny inexact
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic a);
        @(negedge clk);
        in_word = w;
        in_alt  = a;
        in_vld  = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_vld", {31'd0, out_vld}, 32'd0);
        chk("R10 out_half", {16'd0, out_half}, 32'd0);
        chk("R10 flags", {29'd0, out_ovf, out_unf, out_inx}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][50:19], VEC[i][51]);
            @(negedge clk);
            in_vld = 1'b0;
            chk($sformatf("R%0d vld #%0d", VEC[i][55:52], i), {31'd0, out_vld}, 32'd1);
            chk($sformatf("R%0d half #%0d", VEC[i][55:52], i), {16'd0, out_half}, {16'd0, VEC[i][18:3]});
            chk($sformatf("R%0d flags #%0d", VEC[i][55:52], i),
                {29'd0, out_ovf, out_unf, out_inx}, {29'd0, VEC[i][2:0]});
        end

        // R9 hold while in_vld is low
        @(negedge clk);
        in_word = 32'h7f800000;
        in_alt  = 1'b1;
        @(negedge clk);
        chk("R9 vld low", {31'd0, out_vld}, 32'd0);
        chk("R9 half held", {16'd0, out_half}, 32'h0001);
        chk("R9 flags held", {29'd0, out_ovf, out_unf, out_inx}, 32'd3);

        // R9 back to back words
        drive(32'h3f800000, 1'b0);
        @(negedge clk);
        chk("R9 b2b first", {15'd0, out_vld, out_half}, {15'd0, 1'b1, 16'h3c00});
        in_word = 32'hc0000000;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R9 b2b second", {15'd0, out_vld, out_half}, {15'd0, 1'b1, 16'hc000});

        // R10 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 half after reset", {15'd0, out_vld, out_half}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule